// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 18-bit words between a write clock and an unrelated read clock. The write side presents a word with an active-low write enable. The read side takes words with an active-low read enable. Flow control is by flag: a write is accepted only while the full indication reports room, and a read is accepted only while the empty indication reports data. A strobe that the flags refuse is dropped without effect. The producer holds off while `full_n` is low, and the consumer holds off while `empty_n` is low.

Besides full and empty, the block reports three level flags. Two of them are almost-empty and almost-full flags with programmable 12-bit thresholds. The third is a half-full flag. All flags are active low. The thresholds start at a depth-dependent default after reset. They are written and read back through the normal data path while the load strobe `ld_n` is low. The two threshold registers are accessed in a fixed alternation: first almost-empty, then almost-full.

A mode pin, held stable outside reset, selects between two read behaviours. In standard mode a read strobe copies the head word into the output register. In fall-through mode the head word appears on the output by itself. `empty_n` then means "output valid" and `full_n` means "input ready".

Top module: `dcfifo_prog`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the block reports empty with no words held: `full_n`=1, `afull_n`=1, `hfull_n`=1, `empty_n`=0, `aempty_n`=0.
- R2: A rising `wclk` edge with `wr_en_n`=0 and `ld_n`=1 stores `wr_data` only if the FIFO holds fewer than DEPTH (2^ADDR_W) words. `full_n` is 0 exactly while DEPTH words are held. A write attempted while full is dropped, and the stream read out later contains every accepted word once, in write order.
- R3: In standard mode (`fwft`=0), a rising `rclk` edge with `rd_en_n`=0, `ld_n`=1 and `empty_n`=1 loads the oldest word into `rd_data`. While `rd_en_n` is 1, or while the FIFO is empty, `rd_data` keeps its value and nothing is removed.
- R4: `aempty_n` is 0 when the fill level is less than or equal to the almost-empty offset, and 1 above it.
- R5: `afull_n` is 0 when the free space (DEPTH minus fill level) is less than or equal to the almost-full offset, and 1 above it.
- R6: `hfull_n` is 0 exactly while the fill level exceeds DEPTH/2.
- R7: A rising `wclk` edge with `ld_n`=0 and `wr_en_n`=0 stores `wr_data[11:0]` into an offset register instead of the FIFO. The first such access after reset writes the almost-empty offset, the next writes the almost-full offset, and the two keep alternating.
- R8: A rising `rclk` edge with `ld_n`=0 and `rd_en_n`=0 puts an offset register on `rd_data[11:0]`, with `rd_data[17:12]`=0, and removes no word. Read-back alternates in the same order as R7 (almost-empty first after reset) and uses its own toggle.
- R9: In fall-through mode (`fwft`=1), `empty_n`=1 means the oldest word is already on `rd_data` without a strobe. A read edge (`rd_en_n`=0, `ld_n`=1) consumes the shown word and shows the next one. `full_n` acts as input-ready, and capacity stays DEPTH words.
- R10: After reset both offsets equal 31 for DEPTH 256, 63 for DEPTH 512, and 127 for DEPTH 1024 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft | input | 1 | 1 selects fall-through reads; change only during reset |
| ld_n | input | 1 | Active-low strobe redirecting accesses to the offset registers |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Word to store, or offset value in bits 11:0 |
| full_n | output | 1 | Low when full; input-ready in fall-through mode |
| afull_n | output | 1 | Low when free space is at or below the almost-full offset |
| hfull_n | output | 1 | Low when more than half full |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DATA_W | Output register: read word or offset value |
| empty_n | output | 1 | Low when empty; output-valid in fall-through mode |
| aempty_n | output | 1 | Low when the fill level is at or below the almost-empty offset |

## Verification
The write-side flags (`full_n`, `afull_n`, `hfull_n`) follow an accepted write right after that `wclk` edge. They follow a read only after two further `wclk` edges, because the read pointer must pass a synchroniser. The read-side flags (`empty_n`, `aempty_n`) learn of a write after two `rclk` edges, and in fall-through mode the word reaches `rd_data` one `rclk` edge after that. A standard read shows its word just after the consuming edge. The bench therefore waits eight read-clock cycles (more than ten write-clock cycles) after any stimulus before it samples a flag, and it samples each flag on the falling edge of its own domain's clock. The scoreboard monitor takes standard-mode data 1 ns after the consuming edge and fall-through data just before it.

// File: rtl/dcf_pkg.sv
`timescale 1ns/100ps
package dcf_pkg;
  localparam int OFS_W = 12;

  // Reset value of both level offsets as a function of address width.
  function automatic logic [OFS_W-1:0] dflt_ofs(input int aw);
    if (aw >= 10)     return OFS_W'(127);
    else if (aw == 9) return OFS_W'(63);
    else if (aw == 8) return OFS_W'(31);
    else if (aw >= 3) return OFS_W'((1 << aw) / 8 - 1);
    else              return '0;
  endfunction
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/100ps
module dcf_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_i;
      s2 <= s1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits.
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/100ps
module dcf_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/100ps
module dcf_wr_ctrl #(
  parameter int AW = 8,
  parameter int OFS_W = 12,
  parameter logic [OFS_W-1:0] OFS_RST = 31
) (
  input  logic             wclk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic             ld_n,
  input  logic [OFS_W-1:0] ofs_data,
  input  logic [AW:0]      rptr_bin,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [AW:0]      wptr_gray,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             full_n,
  output logic             afull_n,
  output logic             hfull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = ((PW > OFS_W) ? PW : OFS_W) + 1;

  logic [PW-1:0] wptr, wnext, wcnt, wfree;
  logic          wtog, full, push, ofs_ld;

  assign wcnt   = wptr - rptr_bin;
  assign wfree  = PW'(DEPTH) - wcnt;
  assign wnext  = wptr + PW'(1);
  assign full   = (wcnt == PW'(DEPTH));
  assign push   = !wr_en_n && ld_n && !full;
  assign ofs_ld = !wr_en_n && !ld_n;

  assign mem_we    = push;
  assign mem_waddr = wptr[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      wptr_gray <= '0;
      wtog      <= 1'b0;
      ae_ofs    <= OFS_RST;
      af_ofs    <= OFS_RST;
    end else begin
      if (push) begin
        wptr      <= wnext;
        wptr_gray <= wnext ^ (wnext >> 1);
      end
      if (ofs_ld) begin
        if (!wtog) ae_ofs <= ofs_data;
        else       af_ofs <= ofs_data;
        wtog <= ~wtog;
      end
    end
  end

  assign full_n  = !full;
  assign afull_n = CW'(wfree) > CW'(af_ofs);
  assign hfull_n = !(wcnt > PW'(DEPTH / 2));

  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= PW'(DEPTH));
  p_full_blocks_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wr_en_n) |=> $stable(wptr));
  p_load_no_push_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && !ld_n) |=> $stable(wptr));
  p_load_alternates_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_en_n && !ld_n) |=> (wtog != $past(wtog)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/100ps
module dcf_rd_ctrl #(
  parameter int DW = 18,
  parameter int AW = 8,
  parameter int OFS_W = 12
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             fwft,
  input  logic             rd_en_n,
  input  logic             ld_n,
  input  logic [AW:0]      wptr_bin,
  input  logic [DW-1:0]    mem_rdata,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [AW-1:0]    mem_raddr,
  output logic [AW:0]      rptr_gray,
  output logic [DW-1:0]    rd_data,
  output logic             empty_n,
  output logic             aempty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = ((PW > OFS_W) ? PW : OFS_W) + 1;

  logic [PW-1:0] rptr, rnext, rcnt;
  logic          ow, rtog, have, rb, consume;
  logic [DW-1:0] ofs_word;

  assign rcnt     = wptr_bin - rptr;
  assign have     = (rcnt != '0);
  assign rnext    = rptr + PW'(1);
  assign rb       = !rd_en_n && !ld_n;
  assign consume  = !rd_en_n && ld_n && (fwft ? ow : have);
  assign ofs_word = DW'(rtog ? af_ofs : ae_ofs);

  // Fall-through consumption looks one word ahead in the same cycle.
  assign mem_raddr = (fwft && consume) ? rnext[AW-1:0] : rptr[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      rptr_gray <= '0;
      rd_data   <= '0;
      ow        <= 1'b0;
      rtog      <= 1'b0;
    end else if (rb) begin
      rd_data <= ofs_word;
      rtog    <= ~rtog;
      ow      <= 1'b0;
    end else if (consume) begin
      rptr      <= rnext;
      rptr_gray <= rnext ^ (rnext >> 1);
      if (!fwft) begin
        rd_data <= mem_rdata;
      end else if (rcnt != PW'(1)) begin
        rd_data <= mem_rdata;
        ow      <= 1'b1;
      end else begin
        ow <= 1'b0;
      end
    end else if (fwft && !ow && have) begin
      rd_data <= mem_rdata;
      ow      <= 1'b1;
    end
  end

  assign empty_n  = fwft ? ow : have;
  assign aempty_n = CW'(rcnt) > CW'(ae_ofs);

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    !have |=> $stable(rptr));
  p_level_bound_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    rcnt <= PW'(DEPTH));
  p_hold_output_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && rd_en_n) |=> $stable(rd_data));
  p_shown_word_kept_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && ow && rd_en_n) |=> (ow && $stable(rd_data)));
  p_shown_word_stored_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    ow |-> have);
endmodule

// File: rtl/dcfifo_prog.sv
`timescale 1ns/100ps
module dcfifo_prog
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft,
  input  logic              ld_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  output logic              hfull_n,
  input  logic              rd_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [OFS_W-1:0] OFS_RST = dflt_ofs(ADDR_W);

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [PW-1:0]     wptr_gray, rptr_gray, wptr_rs, rptr_ws;
  logic [OFS_W-1:0]  ae_ofs, af_ofs;

  dcf_wr_ctrl #(.AW(ADDR_W), .OFS_W(OFS_W), .OFS_RST(OFS_RST)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
    .ofs_data(wr_data[OFS_W-1:0]), .rptr_bin(rptr_ws),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .wptr_gray(wptr_gray),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .full_n(full_n), .afull_n(afull_n), .hfull_n(hfull_n)
  );

  dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  dcf_ptr_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_i(wptr_gray), .bin_o(wptr_rs)
  );

  dcf_ptr_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_i(rptr_gray), .bin_o(rptr_ws)
  );

  dcf_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W), .OFS_W(OFS_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .rd_en_n(rd_en_n), .ld_n(ld_n),
    .wptr_bin(wptr_rs), .mem_rdata(mem_rdata),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .mem_raddr(mem_raddr), .rptr_gray(rptr_gray),
    .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
  );
endmodule

// File: tb/test_dcfifo_prog.sv
`timescale 1ns/100ps
module test_dcfifo_prog;
  localparam int DW = 18;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft = 1'b0;
  logic          ld_n = 1'b1, wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full_n, afull_n, hfull_n, empty_n, aempty_n;

  int            n_cmp = 0, n_bad = 0;
  logic [DW-1:0] sb [$];
  logic [DW-1:0] seq = 18'h00100;
  logic          wdone = 1'b0, done = 1'b0;
  logic [DW-1:0] v, held;

  always #5   wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  dcfifo_prog #(.DATA_W(DW), .ADDR_W(AW)) i_dcfifo_prog (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .ld_n(ld_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
    .hfull_n(hfull_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmp_pop(input string tag, input logic [DW-1:0] act);
    if (sb.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: actual %0h expected no word", tag, act);
    end else begin
      chk(tag, 32'(act), 32'(sb.pop_front()));
    end
  endtask

  // Monitor: every accepted read is compared against the scoreboard.
  always @(posedge rclk) begin
    if (rst_n && !rd_en_n && ld_n && empty_n) begin
      if (fwft) cmp_pop("R9 fall-through word order", rd_data);
      else begin
        #1;
        cmp_pop("R3 standard word order", rd_data);
      end
    end
  end

  task automatic wr_word(input logic [DW-1:0] d);
    @(posedge wclk); #1;
    while (!full_n) begin @(posedge wclk); #1; end
    wr_en_n = 1'b0; wr_data = d;
    @(posedge wclk);
    sb.push_back(d);
    #1 wr_en_n = 1'b1;
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < k; i++) begin
      wr_word(seq);
      seq = seq + 18'h00107;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; ld_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; fwft = mode;
    repeat (3) @(posedge rclk);
    #1;
    sb.delete();
    rst_n = 1'b1;
    repeat (3) @(posedge wclk);
  endtask

  task automatic ld_word(input logic [DW-1:0] d);
    @(posedge wclk); #1;
    ld_n = 1'b0; wr_en_n = 1'b0; wr_data = d;
    @(posedge wclk); #1;
    ld_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic readback(output logic [DW-1:0] val);
    @(posedge rclk); #1;
    ld_n = 1'b0; rd_en_n = 1'b0;
    @(posedge rclk); #1;
    ld_n = 1'b1; rd_en_n = 1'b1;
    val = rd_data;
  endtask

  task automatic drain();
    int guard = 0;
    @(posedge rclk); #3;
    rd_en_n = 1'b0;
    while (sb.size() != 0 && guard < 5000) begin
      @(posedge rclk); #3;
      guard++;
    end
    rd_en_n = 1'b1;
  endtask

  task automatic traffic(input int n, input int rd_pct);
    wdone = 1'b0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          repeat ($urandom_range(0, 2)) @(posedge wclk);
          wr_word(DW'($urandom));
        end
        wdone = 1'b1;
      end
      begin
        while (!wdone) begin
          @(posedge rclk); #3;
          rd_en_n = !($urandom_range(0, 99) < rd_pct);
        end
        rd_en_n = 1'b1;
      end
    join
    drain();
  endtask

  initial begin
    // ---------------- standard mode, default offsets ----------------
    rst_n = 1'b0;
    repeat (2) @(posedge wclk);
    @(negedge wclk);
    chk("R1 full_n in reset", 32'(full_n), 1);
    chk("R1 afull_n in reset", 32'(afull_n), 1);
    chk("R1 hfull_n in reset", 32'(hfull_n), 1);
    chk("R1 empty_n in reset", 32'(empty_n), 0);
    chk("R1 aempty_n in reset", 32'(aempty_n), 0);
    do_reset(1'b0);
    settle();
    @(negedge rclk);
    chk("R1 empty_n after reset", 32'(empty_n), 0);
    chk("R1 aempty_n after reset", 32'(aempty_n), 0);

    readback(v);
    chk("R10 default almost-empty offset", 32'(v), 31);
    readback(v);
    chk("R10 default almost-full offset", 32'(v), 31);

    fill(31); settle(); @(negedge rclk);
    chk("R4 aempty_n at level 31", 32'(aempty_n), 0);
    chk("R3 empty_n with data", 32'(empty_n), 1);
    fill(1); settle(); @(negedge rclk);
    chk("R4 aempty_n at level 32", 32'(aempty_n), 1);
    fill(96); settle(); @(negedge wclk);
    chk("R6 hfull_n at level 128", 32'(hfull_n), 1);
    fill(1); settle(); @(negedge wclk);
    chk("R6 hfull_n at level 129", 32'(hfull_n), 0);
    fill(95); settle(); @(negedge wclk);
    chk("R5 afull_n at level 224", 32'(afull_n), 1);
    fill(1); settle(); @(negedge wclk);
    chk("R5 afull_n at level 225", 32'(afull_n), 0);
    chk("R2 full_n at level 225", 32'(full_n), 1);
    fill(31); settle(); @(negedge wclk);
    chk("R2 full_n at level 256", 32'(full_n), 0);

    @(posedge wclk); #1;
    wr_en_n = 1'b0; wr_data = 18'h2AAAA;
    repeat (3) @(posedge wclk);
    #1 wr_en_n = 1'b1;
    @(negedge wclk);
    chk("R2 still full after refused writes", 32'(full_n), 0);

    drain(); settle();
    @(negedge rclk);
    chk("R2 no extra word after drain", 32'(empty_n), 0);
    chk("R4 aempty_n after drain", 32'(aempty_n), 0);
    @(negedge wclk);
    chk("R2 full_n after drain", 32'(full_n), 1);

    held = rd_data;
    @(posedge rclk); #1;
    rd_en_n = 1'b0;
    repeat (4) @(posedge rclk);
    #1 rd_en_n = 1'b1;
    @(negedge rclk);
    chk("R3 rd_data kept on read while empty", 32'(rd_data), 32'(held));
    repeat (3) @(posedge rclk);
    @(negedge rclk);
    chk("R3 rd_data kept while idle", 32'(rd_data), 32'(held));

    // ---------------- standard mode, programmed offsets ----------------
    do_reset(1'b0);
    ld_word(18'h3F005);
    ld_word(18'h0000A);
    settle(); @(negedge rclk);
    chk("R7 offset load stores no word", 32'(empty_n), 0);
    readback(v);
    chk("R8 read-back almost-empty offset", 32'(v), 32'h5);
    readback(v);
    chk("R8 read-back almost-full offset", 32'(v), 32'hA);
    readback(v);
    chk("R8 read-back alternation wraps", 32'(v), 32'h5);

    fill(5); settle(); @(negedge rclk);
    chk("R7 aempty_n at programmed level 5", 32'(aempty_n), 0);
    fill(1); settle(); @(negedge rclk);
    chk("R7 aempty_n at programmed level 6", 32'(aempty_n), 1);
    fill(239); settle(); @(negedge wclk);
    chk("R5 afull_n with free space 11", 32'(afull_n), 1);
    fill(1); settle(); @(negedge wclk);
    chk("R5 afull_n with free space 10", 32'(afull_n), 0);
    readback(v);
    chk("R8 read-back leaves data in place", 32'(v), 32'hA);
    settle(); @(negedge wclk);
    chk("R8 level unchanged by read-back", 32'(afull_n), 0);
    drain();

    traffic(300, 60);
    traffic(300, 20);
    settle(); @(negedge rclk);
    chk("R2 standard traffic fully drained", 32'(sb.size()), 0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    settle(); @(negedge rclk);
    chk("R1 output-ready low after reset", 32'(empty_n), 0);
    wr_word(18'h12345);
    settle(); @(negedge rclk);
    chk("R9 output-ready without strobe", 32'(empty_n), 1);
    chk("R9 word shown without strobe", 32'(rd_data), 32'h12345);
    settle(); @(negedge rclk);
    chk("R9 shown word held while idle", 32'(rd_data), 32'h12345);
    fill(254); settle(); @(negedge wclk);
    chk("R9 input-ready at level 255", 32'(full_n), 1);
    fill(1); settle(); @(negedge wclk);
    chk("R9 input-ready low at level 256", 32'(full_n), 0);
    drain(); settle(); @(negedge rclk);
    chk("R9 output-ready low after drain", 32'(empty_n), 0);

    traffic(300, 60);
    traffic(300, 20);
    settle(); @(negedge rclk);
    chk("R9 fall-through traffic fully drained", 32'(sb.size()), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule